// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block tracks in-flight loads and stores so that loads can read memory before the addresses of older stores are known. Loads and stores enter two circular queues in program order. Each entry carries a sequence number that shows its age. A load records its word address and is marked completed when it executes. A store records its word address when that address is computed.

When a store retires, its word address is compared with every executed load in the load queue that is younger than the store. Each matching load is marked with a trap. The mark does not flush anything at once. It is reported only when that load reaches the head of the load queue and the reorder buffer asks it to retire. The trap output is then the request for a pipeline flush. A separate flush input empties both queues and clears every trap mark.

The reorder buffer drives the two retire inputs. A load at the head of the reorder buffer retires only after it has completed. A store at the head of the reorder buffer always retires, and its queue entry is freed.

Top module: `ldst_order_checker`

## Requirements
- R1: Each queue holds 32 entries, filled in program order. The allocation index output shows the tail slot. It is 0 after reset or flush and counts up modulo 32. When a queue is full, its stall output is high and an allocation request does not change that queue.
- R2: After reset both queues are empty: the empty outputs are high, the stall outputs are low and both allocation indices are 0. A load retire request on an empty load queue raises none of the load outcome outputs.
- R3: A load can execute, which records its word address and marks it completed, while the addresses of older stores are still unknown.
- R4: A store retires with a known word address. The word address is the byte address bits 31:2, carried on the word ports. Each load entry that has executed, holds the same word address, and is younger than the store is marked with a trap. A marked load raises the trap output when it reaches the head.
- R5: At store retirement, no trap mark goes to a load that is older than the store, to a load that has not executed, or to a load with a different word address.
- R6: A load that executes in the same cycle as a store retirement is not compared with that store.
- R7: On a load retire request, exactly one outcome is raised when the queue is not empty. The wait output is raised if the head load has not executed, and the head stays. The trap output is raised if the head is marked, and the head stays. Otherwise the retire output is raised and the head advances by one entry.
- R8: A store retire request frees the head store entry and advances the store head by one. On an empty store queue the request is ignored.
- R9: A flush input empties both queues and clears all trap marks at the next clock edge. Allocation restarts at index 0.
- R10: Age uses 8-bit wrapping sequence numbers. A load is younger than a store when (load_seq - store_seq) mod 256 is nonzero and below 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty both queues and drop all trap marks |
| ld_alloc_i | input | 1 | Allocate a load entry at the tail |
| ld_alloc_seq_i | input | 8 | Sequence number of the allocated load |
| ld_alloc_idx_o | output | 5 | Load queue slot that the next allocation takes |
| ld_stall_o | output | 1 | Load queue full; allocation refused |
| ld_exec_i | input | 1 | A load has executed |
| ld_exec_idx_i | input | 5 | Slot of the executed load |
| ld_exec_word_i | input | 30 | Word address read by the load |
| ld_commit_i | input | 1 | The oldest reorder-buffer instruction is a load |
| ld_retire_o | output | 1 | Head load retires and the head advances |
| ld_wait_o | output | 1 | Head load not yet executed; head holds |
| ld_trap_o | output | 1 | Head load is marked; pipeline flush requested |
| ld_empty_o | output | 1 | Load queue holds no entry |
| st_alloc_i | input | 1 | Allocate a store entry at the tail |
| st_alloc_seq_i | input | 8 | Sequence number of the allocated store |
| st_alloc_idx_o | output | 5 | Store queue slot that the next allocation takes |
| st_stall_o | output | 1 | Store queue full; allocation refused |
| st_addr_i | input | 1 | A store address has been computed |
| st_addr_idx_i | input | 5 | Slot of that store |
| st_addr_word_i | input | 30 | Word address of that store |
| st_commit_i | input | 1 | The oldest reorder-buffer instruction is a store |
| st_empty_o | output | 1 | Store queue holds no entry |

## Verification
The bench targets the filters on the match. It uses an older load and a younger load at the same word, a younger load that has not executed, a neighbouring word, and a pair of sequence numbers across the wrap. A design that ignored age, completion or wrap would trap loads that read correct data, or would miss a real violation. The bench also executes a load in the same cycle as a store retires, and a design that matched against incoming execute data would trap that load falsely. The bench retires a trapped load twice and an unexecuted load repeatedly, to show that the head stays. It also retires a store into an empty queue. A design that let its pointers move in these cases would lose or corrupt entries, and the later allocation indices would show it. A flush after a trap must leave no stale mark on the slot that is used again.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    localparam int SEQ_W    = 8;
    localparam int ADDR_W   = 32;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = ADDR_W - WORD_LSB;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        logic  done;
        logic  trap;
        seq_t  seq;
        word_t word;
    } ld_ent_t;

    typedef struct packed {
        logic  valid;
        logic  addr_ok;
        seq_t  seq;
        word_t word;
    } st_ent_t;

    // a is younger than b when (a - b) wraps into the positive half
    function automatic logic seq_younger(seq_t a, seq_t b);
        seq_t diff;
        diff = a - b;
        return (diff != '0) && !diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/lsq_ring.sv
module lsq_ring #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             full_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t st_d, st_q;
    logic  push_ok, pop_ok;

    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = st_q.head;
    assign tail_o  = st_q.tail;
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.tail = st_q.tail + 1'b1;
        if (pop_ok)  st_d.head = st_q.head + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    a_r1_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (empty_o && tail_o == '0));
endmodule

// File: rtl/lsq_load_queue.sv
module lsq_load_queue import lsq_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             alloc_i,
    input  seq_t             alloc_seq_i,
    output logic [IDX_W-1:0] alloc_idx_o,
    output logic             full_o,
    output logic             empty_o,
    input  logic             exec_i,
    input  logic [IDX_W-1:0] exec_idx_i,
    input  word_t            exec_word_i,
    input  logic             chk_i,
    input  seq_t             chk_seq_i,
    input  word_t            chk_word_i,
    input  logic             commit_i,
    output logic             retire_o,
    output logic             wait_o,
    output logic             trap_o
);
    ld_ent_t [DEPTH-1:0] ent_d, ent_q;
    logic    [DEPTH-1:0] hit;
    logic [IDX_W-1:0]    head, tail;
    logic                alloc_ok, busy;
    ld_ent_t             head_ent;

    lsq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .push_i  (alloc_i),
        .pop_i   (retire_o),
        .head_o  (head),
        .tail_o  (tail),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    assign alloc_idx_o = tail;
    assign alloc_ok    = alloc_i && !full_o;
    assign head_ent    = ent_q[head];
    assign busy        = commit_i && !empty_o;
    assign wait_o      = busy && !head_ent.done;
    assign trap_o      = busy && head_ent.done && head_ent.trap;
    assign retire_o    = busy && head_ent.done && !head_ent.trap;

    // one comparator per entry against the retiring store
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit[g] = chk_i && ent_q[g].valid && ent_q[g].done
                     && seq_younger(ent_q[g].seq, chk_seq_i)
                     && (ent_q[g].word == chk_word_i);

        a_r4_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_q[g].trap && !flush_i) |=> ent_q[g].trap);
    end

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) ent_d[i].trap = 1'b1;
            if (exec_i && exec_idx_i == IDX_W'(i) && ent_q[i].valid) begin
                ent_d[i].done = 1'b1;
                ent_d[i].word = exec_word_i;
            end
            if (retire_o && head == IDX_W'(i)) ent_d[i] = '0;
            if (alloc_ok && tail == IDX_W'(i)) begin
                ent_d[i]       = '0;
                ent_d[i].valid = 1'b1;
                ent_d[i].seq   = alloc_seq_i;
            end
        end
        if (flush_i) ent_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    a_r7_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !retire_o && !flush_i) |=> (head == $past(head)));
    a_r7_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_o && !flush_i) |=> (head == IDX_W'($past(head) + 1'b1)));
    a_r9_no_trap_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !trap_o);
endmodule

// File: rtl/lsq_store_queue.sv
module lsq_store_queue import lsq_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             alloc_i,
    input  seq_t             alloc_seq_i,
    output logic [IDX_W-1:0] alloc_idx_o,
    output logic             full_o,
    output logic             empty_o,
    input  logic             addr_i,
    input  logic [IDX_W-1:0] addr_idx_i,
    input  word_t            addr_word_i,
    input  logic             commit_i,
    output logic             chk_o,
    output seq_t             chk_seq_o,
    output word_t            chk_word_o
);
    st_ent_t [DEPTH-1:0] ent_d, ent_q;
    logic [IDX_W-1:0]    head, tail;
    logic                alloc_ok, pop;
    st_ent_t             head_ent;

    lsq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .push_i  (alloc_i),
        .pop_i   (commit_i),
        .head_o  (head),
        .tail_o  (tail),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    assign alloc_idx_o = tail;
    assign alloc_ok    = alloc_i && !full_o;
    assign pop         = commit_i && !empty_o;
    assign head_ent    = ent_q[head];
    assign chk_o       = pop && head_ent.valid && head_ent.addr_ok && !flush_i;
    assign chk_seq_o   = head_ent.seq;
    assign chk_word_o  = head_ent.word;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr_i && addr_idx_i == IDX_W'(i) && ent_q[i].valid) begin
                ent_d[i].addr_ok = 1'b1;
                ent_d[i].word    = addr_word_i;
            end
            if (pop && head == IDX_W'(i)) ent_d[i] = '0;
            if (alloc_ok && tail == IDX_W'(i)) begin
                ent_d[i]       = '0;
                ent_d[i].valid = 1'b1;
                ent_d[i].seq   = alloc_seq_i;
            end
        end
        if (flush_i) ent_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    a_r8_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush_i) |=> (head == IDX_W'($past(head) + 1'b1)));
    a_r8_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && empty_o && !alloc_i && !flush_i) |=> empty_o);
endmodule

// File: rtl/ldst_order_checker.sv
module ldst_order_checker import lsq_pkg::*; #(
    parameter int LQ_DEPTH = 32,
    parameter int SQ_DEPTH = 32,
    localparam int LQ_IDX_W = $clog2(LQ_DEPTH),
    localparam int SQ_IDX_W = $clog2(SQ_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                ld_alloc_i,
    input  logic [SEQ_W-1:0]    ld_alloc_seq_i,
    output logic [LQ_IDX_W-1:0] ld_alloc_idx_o,
    output logic                ld_stall_o,
    input  logic                ld_exec_i,
    input  logic [LQ_IDX_W-1:0] ld_exec_idx_i,
    input  logic [WORD_W-1:0]   ld_exec_word_i,
    input  logic                ld_commit_i,
    output logic                ld_retire_o,
    output logic                ld_wait_o,
    output logic                ld_trap_o,
    output logic                ld_empty_o,
    input  logic                st_alloc_i,
    input  logic [SEQ_W-1:0]    st_alloc_seq_i,
    output logic [SQ_IDX_W-1:0] st_alloc_idx_o,
    output logic                st_stall_o,
    input  logic                st_addr_i,
    input  logic [SQ_IDX_W-1:0] st_addr_idx_i,
    input  logic [WORD_W-1:0]   st_addr_word_i,
    input  logic                st_commit_i,
    output logic                st_empty_o
);
    logic  chk;
    seq_t  chk_seq;
    word_t chk_word;

    lsq_store_queue #(.DEPTH(SQ_DEPTH)) u_sq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .alloc_i     (st_alloc_i),
        .alloc_seq_i (st_alloc_seq_i),
        .alloc_idx_o (st_alloc_idx_o),
        .full_o      (st_stall_o),
        .empty_o     (st_empty_o),
        .addr_i      (st_addr_i),
        .addr_idx_i  (st_addr_idx_i),
        .addr_word_i (st_addr_word_i),
        .commit_i    (st_commit_i),
        .chk_o       (chk),
        .chk_seq_o   (chk_seq),
        .chk_word_o  (chk_word)
    );

    lsq_load_queue #(.DEPTH(LQ_DEPTH)) u_lq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .alloc_i     (ld_alloc_i),
        .alloc_seq_i (ld_alloc_seq_i),
        .alloc_idx_o (ld_alloc_idx_o),
        .full_o      (ld_stall_o),
        .empty_o     (ld_empty_o),
        .exec_i      (ld_exec_i),
        .exec_idx_i  (ld_exec_idx_i),
        .exec_word_i (ld_exec_word_i),
        .chk_i       (chk),
        .chk_seq_i   (chk_seq),
        .chk_word_i  (chk_word),
        .commit_i    (ld_commit_i),
        .retire_o    (ld_retire_o),
        .wait_o      (ld_wait_o),
        .trap_o      (ld_trap_o)
    );

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_retire_o, ld_wait_o, ld_trap_o}));
    a_r7_outcome_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_commit_i || ld_empty_o) |-> !(ld_retire_o || ld_wait_o || ld_trap_o));
endmodule

// File: tb/ldst_order_checker_tb.sv
module ldst_order_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        ld_alloc_i = 1'b0;
    logic [7:0]  ld_alloc_seq_i = '0;
    logic [4:0]  ld_alloc_idx_o;
    logic        ld_stall_o;
    logic        ld_exec_i = 1'b0;
    logic [4:0]  ld_exec_idx_i = '0;
    logic [29:0] ld_exec_word_i = '0;
    logic        ld_commit_i = 1'b0;
    logic        ld_retire_o, ld_wait_o, ld_trap_o, ld_empty_o;
    logic        st_alloc_i = 1'b0;
    logic [7:0]  st_alloc_seq_i = '0;
    logic [4:0]  st_alloc_idx_o;
    logic        st_stall_o;
    logic        st_addr_i = 1'b0;
    logic [4:0]  st_addr_idx_i = '0;
    logic [29:0] st_addr_word_i = '0;
    logic        st_commit_i = 1'b0;
    logic        st_empty_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam int OK = 1, WAIT = 2, TRAP = 4;

    always #10 clk = ~clk;

    ldst_order_checker u_dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ld_alloc(input logic [7:0] s, output logic [4:0] idx);
        ld_alloc_i = 1'b1; ld_alloc_seq_i = s;
        #1 idx = ld_alloc_idx_o;
        step();
        ld_alloc_i = 1'b0;
    endtask

    task automatic ld_exec(input logic [4:0] idx, input logic [29:0] w);
        ld_exec_i = 1'b1; ld_exec_idx_i = idx; ld_exec_word_i = w;
        step();
        ld_exec_i = 1'b0;
    endtask

    task automatic st_alloc(input logic [7:0] s, output logic [4:0] idx);
        st_alloc_i = 1'b1; st_alloc_seq_i = s;
        #1 idx = st_alloc_idx_o;
        step();
        st_alloc_i = 1'b0;
    endtask

    task automatic st_addr(input logic [4:0] idx, input logic [29:0] w);
        st_addr_i = 1'b1; st_addr_idx_i = idx; st_addr_word_i = w;
        step();
        st_addr_i = 1'b0;
    endtask

    task automatic st_commit();
        st_commit_i = 1'b1;
        step();
        st_commit_i = 1'b0;
    endtask

    task automatic ld_commit(string tag, int exp);
        ld_commit_i = 1'b1;
        #1 chk(tag, {29'd0, ld_trap_o, ld_wait_o, ld_retire_o}, exp);
        step();
        ld_commit_i = 1'b0;
    endtask

    task automatic do_flush();
        flush_i = 1'b1;
        step();
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 ld_empty", ld_empty_o, 1);
        chk("R2 st_empty", st_empty_o, 1);
        chk("R2 ld_stall", ld_stall_o, 0);
        chk("R2 st_stall", st_stall_o, 0);
        chk("R2 ld_idx", ld_alloc_idx_o, 0);
        chk("R2 st_idx", st_alloc_idx_o, 0);
        ld_commit("R2 empty commit no outcome", 0);
    endtask

    task automatic t_basic();
        logic [4:0] si, li;
        st_alloc(8'd10, si);
        ld_alloc(8'd11, li);
        ld_exec(li, 30'h100);            // R3: store address still unknown
        st_addr(si, 30'h100);
        st_commit();
        chk("R8 st_empty after commit", st_empty_o, 1);
        ld_commit("R4 younger match traps", TRAP);
        ld_commit("R7 trapped head holds", TRAP);
        do_flush();
    endtask

    task automatic t_filters();
        logic [4:0] si, l0, l1, l2, l3;
        st_alloc(8'd20, si);
        ld_alloc(8'd19, l0);
        ld_alloc(8'd21, l1);
        ld_alloc(8'd22, l2);
        ld_alloc(8'd23, l3);
        ld_exec(l0, 30'h200);
        ld_exec(l2, 30'h201);
        ld_exec(l3, 30'h200);
        st_addr(si, 30'h200);
        st_commit();
        ld_commit("R5 older load not marked", OK);
        ld_commit("R7 unexecuted head waits", WAIT);
        ld_exec(l1, 30'h200);
        ld_commit("R5 unexecuted load not marked", OK);
        ld_commit("R5 other word not marked", OK);
        ld_commit("R4 matching younger load traps", TRAP);
        do_flush();
    endtask

    task automatic t_same_cycle();
        logic [4:0] si, li;
        st_alloc(8'd30, si);
        st_addr(si, 30'h300);
        ld_alloc(8'd31, li);
        ld_exec_i = 1'b1; ld_exec_idx_i = li; ld_exec_word_i = 30'h300;
        st_commit_i = 1'b1;
        step();
        ld_exec_i = 1'b0; st_commit_i = 1'b0;
        ld_commit("R6 same-cycle execute not marked", OK);
        chk("R6 ld_empty", ld_empty_o, 1);
    endtask

    task automatic t_wrap();
        logic [4:0] si, l0, l1;
        st_alloc(8'd250, si);
        ld_alloc(8'd245, l0);
        ld_alloc(8'd3, l1);
        ld_exec(l0, 30'h400);
        ld_exec(l1, 30'h400);
        st_addr(si, 30'h400);
        st_commit();
        ld_commit("R10 seq 245 older than 250", OK);
        ld_commit("R10 seq 3 younger than 250", TRAP);
        do_flush();
    endtask

    task automatic t_wait();
        logic [4:0] li;
        ld_alloc(8'd40, li);
        ld_commit("R7 wait first", WAIT);
        ld_commit("R7 wait again", WAIT);
        chk("R7 head kept", ld_empty_o, 0);
        ld_exec(li, 30'h10);
        ld_commit("R7 retire after execute", OK);
        chk("R7 empty after retire", ld_empty_o, 1);
        do_flush();
    endtask

    task automatic t_full();
        logic [4:0] idx;
        for (int i = 0; i < 32; i++) begin
            ld_alloc(8'(50 + i), idx);
            chk("R1 ld index order", idx, i);
        end
        chk("R1 ld stall full", ld_stall_o, 1);
        ld_alloc(8'd99, idx);
        chk("R1 ld stall kept", ld_stall_o, 1);
        for (int i = 0; i < 32; i++) ld_exec(5'(i), 30'(i));
        for (int i = 0; i < 32; i++) ld_commit("R1 drain ld", OK);
        chk("R1 ld empty after drain", ld_empty_o, 1);
        for (int i = 0; i < 32; i++) begin
            st_alloc(8'(100 + i), idx);
            chk("R1 st index order", idx, i);
        end
        chk("R1 st stall full", st_stall_o, 1);
        st_alloc(8'd200, idx);
        for (int i = 0; i < 32; i++) st_commit();
        chk("R1 st empty after drain", st_empty_o, 1);
        st_commit();                     // R8: empty queue, ignored
        chk("R8 still empty", st_empty_o, 1);
        st_alloc(8'd140, idx);
        chk("R8 index after ignored commit", idx, 0);
        chk("R8 not empty", st_empty_o, 0);
        st_commit();
        chk("R8 empty again", st_empty_o, 1);
        do_flush();
    endtask

    task automatic t_flush();
        logic [4:0] si, li;
        st_alloc(8'd59, si);
        ld_alloc(8'd60, li);
        ld_exec(li, 30'h500);
        st_addr(si, 30'h500);
        st_commit();
        ld_alloc(8'd61, li);
        do_flush();
        chk("R9 ld empty", ld_empty_o, 1);
        chk("R9 st empty", st_empty_o, 1);
        chk("R9 ld idx restart", ld_alloc_idx_o, 0);
        ld_alloc(8'd62, li);
        ld_exec(li, 30'h500);
        ld_commit("R9 no stale trap", OK);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_filters();
        t_same_cycle();
        t_wrap();
        t_wait();
        t_full();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule